// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider Pair

This block holds the digital counters of an integer-N frequency synthesizer. The feedback path divides the VCO-side input clock with a dual-modulus prescaler that a swallow counter switches between P+1 and P. A programmable main counter sets the length of one feedback cycle. The total division is P·B + A, where A is the swallow count, B is the main count, and the base modulus P is 32 or 64 as chosen by a select input. The reference path divides the oscillator clock by R. Each path emits a one-clock pulse at the end of every division cycle. A phase detector elsewhere compares the two pulse trains.

Each configuration input is sampled in its own clock domain. The feedback settings (A, B, select) are sampled on the VCO-side clock and R on the oscillator clock. A sampled value that passes the legality rules is kept in a holding register. The running counters copy the holding register only when their current cycle ends, so a change never distorts a cycle that is already under way. A value that breaks the rules is not stored: the path's error flag rises and the path keeps dividing by its last legal setting.

Top module: `pswl_divider_pair`

## Requirements
- R1: While rst_ni is low both pulse outputs and both error flags are low. After release the feedback path runs with A=0, B=3 and select 0, and its first pulse appears exactly 96 input-clock cycles after the release.
- R2: With mod_sel_i=0 the feedback pulse period is 32·B + A cycles of fin_clk_i.
- R3: With mod_sel_i=1 the feedback pulse period is 64·B + A cycles of fin_clk_i.
- R4: The corner settings A=0 (all cycles at P) and A=B (all cycles at P+1) give P·B + A. This includes the largest setting A=B=63.
- R5: The reference pulse period is R cycles of osc_clk_i for any legal R, including 3 and 63.
- R6: Each pulse output is high for exactly one cycle of its own clock per division cycle.
- R7: A new legal setting applied during a division cycle leaves that cycle's length unchanged. It governs only the cycles after the next pulse.
- R8: If the sampled feedback setting has B < 3 or B < A, fb_err_o is high after the next fin_clk_i edge and the period stays at the last legal value. A legal setting clears fb_err_o on the next edge.
- R9: If the sampled R is below 3, ref_err_o is high after the next osc_clk_i edge and the reference period stays at the last legal value. A legal R clears ref_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk_i | input | 1 | VCO-side input clock of the feedback path |
| osc_clk_i | input | 1 | Oscillator clock of the reference path |
| rst_ni | input | 1 | Asynchronous active-low reset for both paths |
| swallow_i | input | 6 | Swallow count A (0 to 63) |
| main_i | input | 6 | Main count B (3 to 63, not below A) |
| mod_sel_i | input | 1 | Base modulus select: 0 gives 32/33, 1 gives 64/65 |
| ref_div_i | input | 6 | Reference division R (3 to 63) |
| fb_pulse_o | output | 1 | One-cycle pulse per completed feedback cycle |
| ref_pulse_o | output | 1 | One-cycle pulse per completed reference cycle |
| fb_err_o | output | 1 | Sampled feedback setting is illegal |
| ref_err_o | output | 1 | Sampled reference setting is illegal |

## Verification
The error flags follow one clock edge after the setting is sampled. A period change shows up only in the interval that starts at the first pulse after the holding register is loaded. The bench therefore changes settings at the falling edge right after a pulse. It counts falling edges until the next pulse and expects the old period there. It then counts one more interval and expects the new period. Error flags and pulse levels are sampled only at falling edges, half a clock after the edge that updates them.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  typedef enum logic {
    PS_LO = 1'b0,
    PS_HI = 1'b1
  } ps_sel_e;
endpackage

// File: rtl/pswl_cfg_hold.sv
// Holds the last legal setting; err_o mirrors the legality of the last sample.
module pswl_cfg_hold #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  input  logic         legal_i,
  output logic [W-1:0] cfg_o,
  output logic         err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= RST_VAL;
      err_o <= 1'b0;
    end else if (legal_i) begin
      cfg_o <= cfg_i;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
  import pswl_pkg::*;
#(
  parameter int unsigned P_LO = 32
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ps_sel_e sel_i,
  input  logic    plus1_i,
  output logic    tick_o
);
  localparam int unsigned PS_W = $clog2(2 * P_LO + 1);
  localparam logic [PS_W-1:0] LO_M1 = PS_W'(P_LO - 1);
  localparam logic [PS_W-1:0] HI_M1 = PS_W'(2 * P_LO - 1);

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] last_q;

  always_comb begin
    last_q = (sel_i == PS_HI) ? HI_M1 : LO_M1;
    last_q = last_q + PS_W'(plus1_i);
  end

  assign tick_o = (ps_cnt == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_cnt <= '0;
    else if (tick_o) ps_cnt <= '0;
    else ps_cnt <= ps_cnt + 1'b1;
  end
endmodule

// File: rtl/pswl_fb_div.sv
module pswl_fb_div
  import pswl_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned P_LO = 32,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_B = 3,
  parameter bit RST_SEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  input  ps_sel_e          sel_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] a_cnt;
  logic [CNT_W-1:0] b_cnt;
  ps_sel_e          sel_act;
  logic             tick;
  logic             swallow_on;

  assign swallow_on = (a_cnt != '0);

  pswl_prescaler #(.P_LO(P_LO)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_act),
    .plus1_i(swallow_on),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt   <= CNT_W'(RST_A);
      b_cnt   <= CNT_W'(RST_B);
      sel_act <= ps_sel_e'(RST_SEL);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick) begin
        if (b_cnt == CNT_W'(1)) begin
          // end of feedback cycle: reload all active values together
          a_cnt   <= a_i;
          b_cnt   <= b_i;
          sel_act <= sel_i;
          pulse_o <= 1'b1;
        end else begin
          b_cnt <= b_cnt - 1'b1;
          if (swallow_on) a_cnt <= a_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pswl_ref_div.sv
module pswl_ref_div #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned RST_R = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] r_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] r_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_cnt   <= CNT_W'(RST_R);
      pulse_o <= 1'b0;
    end else if (r_cnt == CNT_W'(1)) begin
      r_cnt   <= r_i;
      pulse_o <= 1'b1;
    end else begin
      r_cnt   <= r_cnt - 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pswl_divider_pair.sv
module pswl_divider_pair
  import pswl_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned P_LO = 32,
  parameter int unsigned MIN_DIV = 3,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_B = 3,
  parameter bit RST_SEL = 1'b0,
  parameter int unsigned RST_R = 3
) (
  input  logic             fin_clk_i,
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] swallow_i,
  input  logic [CNT_W-1:0] main_i,
  input  logic             mod_sel_i,
  input  logic [CNT_W-1:0] ref_div_i,
  output logic             fb_pulse_o,
  output logic             ref_pulse_o,
  output logic             fb_err_o,
  output logic             ref_err_o
);
  localparam int unsigned FB_W = 2 * CNT_W + 1;
  localparam logic [FB_W-1:0] FB_RST = {RST_SEL, CNT_W'(RST_A), CNT_W'(RST_B)};
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DIV);

  logic [FB_W-1:0]  fb_cfg;
  logic             fb_legal;
  logic [CNT_W-1:0] r_cfg;
  logic             r_legal;

  assign fb_legal = (main_i >= MIN_V) && (main_i >= swallow_i);
  assign r_legal  = (ref_div_i >= MIN_V);

  pswl_cfg_hold #(.W(FB_W), .RST_VAL(FB_RST)) u_fb_hold (
    .clk_i  (fin_clk_i),
    .rst_ni (rst_ni),
    .cfg_i  ({mod_sel_i, swallow_i, main_i}),
    .legal_i(fb_legal),
    .cfg_o  (fb_cfg),
    .err_o  (fb_err_o)
  );

  pswl_cfg_hold #(.W(CNT_W), .RST_VAL(CNT_W'(RST_R))) u_ref_hold (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (ref_div_i),
    .legal_i(r_legal),
    .cfg_o  (r_cfg),
    .err_o  (ref_err_o)
  );

  pswl_fb_div #(
    .CNT_W  (CNT_W),
    .P_LO   (P_LO),
    .RST_A  (RST_A),
    .RST_B  (RST_B),
    .RST_SEL(RST_SEL)
  ) u_fb (
    .clk_i  (fin_clk_i),
    .rst_ni (rst_ni),
    .a_i    (fb_cfg[CNT_W +: CNT_W]),
    .b_i    (fb_cfg[0 +: CNT_W]),
    .sel_i  (ps_sel_e'(fb_cfg[FB_W-1])),
    .pulse_o(fb_pulse_o)
  );

  pswl_ref_div #(.CNT_W(CNT_W), .RST_R(RST_R)) u_ref (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .r_i    (r_cfg),
    .pulse_o(ref_pulse_o)
  );
endmodule

// File: rtl/pswl_divider_pair_chk.sv
module pswl_divider_pair_chk #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned P_LO = 32,
  parameter int unsigned MIN_DIV = 3
) (
  input logic             fin_clk_i,
  input logic             osc_clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] swallow_i,
  input logic [CNT_W-1:0] main_i,
  input logic [CNT_W-1:0] ref_div_i,
  input logic             fb_pulse_o,
  input logic             ref_pulse_o,
  input logic             fb_err_o,
  input logic             ref_err_o
);
  localparam int unsigned CMAX   = (1 << CNT_W) - 1;
  localparam int unsigned FB_MIN = P_LO * MIN_DIV;
  localparam int unsigned FB_MAX = 2 * P_LO * CMAX + CMAX;
  localparam int unsigned GAP_W  = $clog2(FB_MAX + 2);
  localparam int unsigned RG_W   = CNT_W + 1;

  logic [GAP_W-1:0] fb_gap;
  logic [RG_W-1:0]  ref_gap;

  always_ff @(posedge fin_clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_gap <= '0;
    else if (fb_pulse_o) fb_gap <= '0;
    else if (fb_gap != '1) fb_gap <= fb_gap + 1'b1;
  end

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_gap <= '0;
    else if (ref_pulse_o) ref_gap <= '0;
    else if (ref_gap != '1) ref_gap <= ref_gap + 1'b1;
  end

  AST_FB_ERR_SET: assert property (@(posedge fin_clk_i) disable iff (!rst_ni)
    ((main_i < CNT_W'(MIN_DIV)) || (main_i < swallow_i)) |=> fb_err_o); // R8
  AST_FB_ERR_CLR: assert property (@(posedge fin_clk_i) disable iff (!rst_ni)
    ((main_i >= CNT_W'(MIN_DIV)) && (main_i >= swallow_i)) |=> !fb_err_o); // R8
  AST_REF_ERR_SET: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (ref_div_i < CNT_W'(MIN_DIV)) |=> ref_err_o); // R9
  AST_FB_PULSE_ONE: assert property (@(posedge fin_clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R6
  AST_REF_PULSE_ONE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o); // R6
  AST_FB_GAP_MIN: assert property (@(posedge fin_clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> (fb_gap >= GAP_W'(FB_MIN - 1))); // R2
  AST_FB_GAP_MAX: assert property (@(posedge fin_clk_i) disable iff (!rst_ni)
    fb_gap <= GAP_W'(FB_MAX)); // R3
  AST_REF_GAP_MAX: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    ref_gap <= RG_W'(CMAX)); // R5
endmodule

bind pswl_divider_pair pswl_divider_pair_chk #(
  .CNT_W  (CNT_W),
  .P_LO   (P_LO),
  .MIN_DIV(MIN_DIV)
) u_chk (
  .fin_clk_i  (fin_clk_i),
  .osc_clk_i  (osc_clk_i),
  .rst_ni     (rst_ni),
  .swallow_i  (swallow_i),
  .main_i     (main_i),
  .ref_div_i  (ref_div_i),
  .fb_pulse_o (fb_pulse_o),
  .ref_pulse_o(ref_pulse_o),
  .fb_err_o   (fb_err_o),
  .ref_err_o  (ref_err_o)
);

// File: tb/pswl_divider_pair_bench.sv
`timescale 1ns/1ps
module pswl_divider_pair_bench;
  logic       fin_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n;
  logic [5:0] swl, mn, rdv;
  logic       msel;
  logic       fb_pulse, ref_pulse, fb_err, ref_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cur_fb;
  int cur_ref;

  always #4 fin_clk = ~fin_clk;
  always #5 osc_clk = ~osc_clk;

  pswl_divider_pair u_pswl_divider_pair (
    .fin_clk_i  (fin_clk),
    .osc_clk_i  (osc_clk),
    .rst_ni     (rst_n),
    .swallow_i  (swl),
    .main_i     (mn),
    .mod_sel_i  (msel),
    .ref_div_i  (rdv),
    .fb_pulse_o (fb_pulse),
    .ref_pulse_o(ref_pulse),
    .fb_err_o   (fb_err),
    .ref_err_o  (ref_err)
  );

  function automatic int exp_fb(int a, int b, bit s);
    return (s ? 64 : 32) * b + a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts fin_clk falling edges until fb pulse; checks width at first edge
  task automatic fb_interval(output int n);
    n = 0;
    do begin
      @(negedge fin_clk);
      n++;
      if (n == 1) check(!fb_pulse, "R6", int'(fb_pulse), 0);
    end while (!fb_pulse || n == 1);
  endtask

  task automatic ref_interval(output int n);
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
      if (n == 1) check(!ref_pulse, "R6", int'(ref_pulse), 0);
    end while (!ref_pulse || n == 1);
  endtask

  // called at the falling edge where fb_pulse is seen
  task automatic run_fb(int a, int b, bit s, string req);
    int n;
    int e;
    e = exp_fb(a, b, s);
    swl = 6'(a); mn = 6'(b); msel = s;
    fb_interval(n);
    check(n == cur_fb, "R7", n, cur_fb);
    check(!fb_err, "R8", int'(fb_err), 0);
    fb_interval(n);
    check(n == e, req, n, e);
    cur_fb = e;
  endtask

  task automatic bad_fb(int a, int b);
    int n;
    swl = 6'(a); mn = 6'(b);
    fb_interval(n);
    check(n == cur_fb, "R8", n, cur_fb);
    check(fb_err, "R8", int'(fb_err), 1);
    fb_interval(n);
    check(n == cur_fb, "R8", n, cur_fb);
  endtask

  task automatic run_ref(int r, string req);
    int n;
    rdv = 6'(r);
    ref_interval(n);
    check(n == cur_ref, "R7", n, cur_ref);
    check(!ref_err, "R9", int'(ref_err), 0);
    ref_interval(n);
    check(n == r, req, n, r);
    cur_ref = r;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5EED_2026));
    rst_n = 1'b0; swl = 6'd0; mn = 6'd3; msel = 1'b0; rdv = 6'd3;
    repeat (5) @(negedge fin_clk);
    check(!fb_pulse && !ref_pulse, "R1", int'({fb_pulse, ref_pulse}), 0);
    check(!fb_err && !ref_err, "R1", int'({fb_err, ref_err}), 0);
    rst_n = 1'b1;
    fb_interval(n);
    check(n == 96, "R1", n, 96);
    cur_fb = 96;

    run_fb(17, 40, 1'b0, "R2");
    run_fb(0, 3, 1'b1, "R3");
    run_fb(5, 5, 1'b0, "R4");
    run_fb(0, 63, 1'b0, "R4");
    run_fb(63, 63, 1'b1, "R4");
    run_fb(9, 21, 1'b1, "R3");
    for (int i = 0; i < 6; i++) begin
      int b;
      int a;
      bit s;
      s = 1'($urandom % 2);
      b = 3 + int'($urandom % 61);
      a = int'($urandom % (b + 1));
      run_fb(a, b, s, s ? "R3" : "R2");
    end
    run_fb(4, 12, 1'b0, "R2");
    bad_fb(0, 2);
    bad_fb(10, 5);
    run_fb(3, 9, 1'b0, "R2");

    // reference path
    do @(negedge osc_clk); while (!ref_pulse);
    cur_ref = 3;
    run_ref(63, "R5");
    run_ref(7, "R5");
    for (int i = 0; i < 4; i++) run_ref(3 + int'($urandom % 61), "R5");
    run_ref(3, "R5");
    rdv = 6'd2;
    ref_interval(n);
    check(n == cur_ref, "R9", n, cur_ref);
    check(ref_err, "R9", int'(ref_err), 1);
    rdv = 6'd0;
    ref_interval(n);
    check(n == cur_ref, "R9", n, cur_ref);
    check(ref_err, "R9", int'(ref_err), 1);
    run_ref(11, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge fin_clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule